// File: doc/BRIEF.md
# I2C Line Conditioner and Bus Event Detector

This block sits between the raw SCL and SDA pads of a two-wire serial slave and its protocol engine. It runs on a fast system clock and oversamples both lines. Each line passes through a two-flop synchronizer and then a persistence filter. The filter accepts a new level only after it has been seen for a set number of consecutive samples, so short spikes never reach the logic behind it. From the filtered levels the block produces single-cycle strobes for start, stop, SCL rising edge and SCL falling edge. It also keeps the data bit that was on SDA at the last SCL rising edge.

A gate input lets the slave go deaf while it runs its internal programming cycle. While the gate is high, every strobe is suppressed and the captured data bit is frozen. The filters keep tracking the lines during this time, so releasing the gate never creates a false event.

Top module: `i2c_line_cond`

## Requirements
- R1: During and right after synchronous reset (rst_n low), all four strobes are low and rx_bit is 1. Both filtered lines start at the idle-high level.
- R2: A level change on either raw line that lasts fewer than FILT_LEN system clock cycles produces no strobe. FILT_LEN = SPIKE_NS / CLK_PERIOD_NS + 1, which is 11 by default, so a 100 ns spike at a 10 ns clock is rejected.
- R3: A level held for at least FILT_LEN cycles is accepted. The resulting strobe is high in the cycle that follows the (FILT_LEN+2)-th rising clock edge after the raw change: two synchronizer edges plus FILT_LEN filter samples.
- R4: ev_start pulses for exactly one cycle when filtered SDA falls while filtered SCL was high and stays high.
- R5: ev_stop pulses for exactly one cycle when filtered SDA rises while filtered SCL was high and stays high.
- R6: ev_scl_rise and ev_scl_fall each pulse for exactly one cycle on a filtered SCL 0-to-1 or 1-to-0 transition.
- R7: When an unmasked SCL rising strobe occurs, rx_bit takes the filtered SDA level at the next clock edge. At all other times rx_bit holds its value.
- R8: While bus_gate is high, all four strobes are low and rx_bit does not change. Releasing the gate produces no strobe unless the lines themselves move.
- R9: At most one of the four strobes is high in any cycle.
- R10: SDA transitions made while filtered SCL is low produce neither ev_start nor ev_stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System oversampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_raw | input | 1 | Unsynchronized serial clock line |
| sda_raw | input | 1 | Unsynchronized serial data line |
| bus_gate | input | 1 | High masks all bus events (internal write cycle) |
| ev_start | output | 1 | One-cycle start condition strobe |
| ev_stop | output | 1 | One-cycle stop condition strobe |
| ev_scl_rise | output | 1 | One-cycle filtered SCL rising edge strobe |
| ev_scl_fall | output | 1 | One-cycle filtered SCL falling edge strobe |
| rx_bit | output | 1 | SDA level captured at the last unmasked SCL rise |

## Verification
The properties assume that the strobes come from filtered levels that change at most once per clock cycle per line. They also assume that bus_gate changes only between clock edges, because it masks the strobes without a register. The stimulus drives every input just after the falling clock edge. It keeps SCL and SDA transitions at least several filter lengths apart, except in the spike cases, which are applied with SCL high so that an accepted spike would show up as a start or stop. A behavioural model in the bench predicts every strobe and rx_bit on every cycle, and directed scenarios add exact-latency and event-count checks.

// File: rtl/i2c_lc_pkg.sv
// Shared types and helpers for the I2C line conditioner.
// Assumes integer nanosecond clock period and spike width.
package i2c_lc_pkg;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } bus_evt_t;

    // Number of consecutive equal samples needed to accept a new level:
    // one more than the samples a maximal spike can cover.
    function automatic int calc_filt_len(input int clk_ns, input int spike_ns);
        return (spike_ns / clk_ns) + 1;
    endfunction

endpackage

// File: rtl/i2c_lc_sync.sv
// Multi-flop synchronizer for one asynchronous line.
// Assumes STAGES >= 2; resets to RST_VAL (idle level of the bus line).
module i2c_lc_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh;

    // Shift the raw line through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh <= {STAGES{RST_VAL}};
        end else begin
            sh[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                sh[i] <= sh[i-1];
            end
        end
    end

    assign q = sh[STAGES-1];
endmodule

// File: rtl/i2c_lc_glitch.sv
// Persistence filter: the output follows the input only after the input
// has differed from the output for FILT_LEN consecutive samples.
// Assumes a synchronized input; output resets to the idle-high level.
module i2c_lc_glitch #(
    parameter int FILT_LEN = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int CNT_W = (FILT_LEN > 1) ? $clog2(FILT_LEN + 1) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FILT_LEN - 1);

    logic [CNT_W-1:0] run_cnt;
    logic             level_q;

    // Count how long the input disagrees; flip once the run is long enough.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
            level_q <= 1'b1;
        end else if (din == level_q) begin
            run_cnt <= '0;
        end else if (run_cnt == LAST) begin
            run_cnt <= '0;
            level_q <= din;
        end else begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    assign dout = level_q;
endmodule

// File: rtl/i2c_lc_events.sv
// Turns filtered SCL/SDA levels into one-cycle condition strobes and
// captures the data bit on each SCL rise. A gate input masks all strobes.
// Assumes each filtered level changes at most once per cycle.
module i2c_lc_events
    import i2c_lc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_f,
    input  logic     sda_f,
    input  logic     gate,
    output bus_evt_t evt,
    output logic     rx_bit
);
    logic     scl_q;
    logic     sda_q;
    logic     rx_q;
    bus_evt_t raw_evt;

    // Remember the previous filtered levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    // Classify the transition seen between previous and current levels.
    always_comb begin
        raw_evt.start = scl_q & scl_f & sda_q & ~sda_f;
        raw_evt.stop  = scl_q & scl_f & ~sda_q & sda_f;
        raw_evt.rise  = ~scl_q & scl_f;
        raw_evt.fall  = scl_q & ~scl_f;
    end

    // Suppress every strobe while the gate is held.
    always_comb begin
        evt = gate ? '0 : raw_evt;
    end

    // Capture SDA on each reported SCL rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q <= 1'b1;
        end else if (evt.rise) begin
            rx_q <= sda_f;
        end
    end

    assign rx_bit = rx_q;
endmodule

// File: rtl/i2c_line_cond.sv
// Top level: synchronizes and filters SCL and SDA, then detects bus events.
// Assumes clk is much faster than the bus; CLK_PERIOD_NS and SPIKE_NS set
// the filter length.
module i2c_line_cond
    import i2c_lc_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 10,
    parameter int SPIKE_NS      = 100,
    parameter int SYNC_STAGES   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    input  logic bus_gate,
    output logic ev_start,
    output logic ev_stop,
    output logic ev_scl_rise,
    output logic ev_scl_fall,
    output logic rx_bit
);
    localparam int FILT_LEN = calc_filt_len(CLK_PERIOD_NS, SPIKE_NS);
    localparam int N_LINES  = 2;  // index 0 = SCL, 1 = SDA

    logic [N_LINES-1:0] raw_lines;
    logic [N_LINES-1:0] sync_lines;
    logic [N_LINES-1:0] filt_lines;
    bus_evt_t           evt;

    assign raw_lines = {sda_raw, scl_raw};

    // One synchronizer and one spike filter per bus line.
    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        i2c_lc_sync #(
            .STAGES (SYNC_STAGES),
            .RST_VAL(1'b1)
        ) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .d    (raw_lines[g]),
            .q    (sync_lines[g])
        );

        i2c_lc_glitch #(
            .FILT_LEN(FILT_LEN)
        ) u_filt (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (sync_lines[g]),
            .dout (filt_lines[g])
        );
    end

    i2c_lc_events u_evt (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_f (filt_lines[0]),
        .sda_f (filt_lines[1]),
        .gate  (bus_gate),
        .evt   (evt),
        .rx_bit(rx_bit)
    );

    assign ev_start    = evt.start;
    assign ev_stop     = evt.stop;
    assign ev_scl_rise = evt.rise;
    assign ev_scl_fall = evt.fall;
endmodule

// File: rtl/i2c_lc_checker.sv
// Port-level properties of the I2C line conditioner, bound to the top.
// Assumes bus_gate changes only between clock edges.
module i2c_lc_checker (
    input logic clk,
    input logic rst_n,
    input logic bus_gate,
    input logic ev_start,
    input logic ev_stop,
    input logic ev_scl_rise,
    input logic ev_scl_fall,
    input logic rx_bit
);
    assert_strobes_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ev_start, ev_stop, ev_scl_rise, ev_scl_fall}));

    assert_start_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ev_start |=> !ev_start);

    assert_stop_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ev_stop |=> !ev_stop);

    assert_rise_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ev_scl_rise |=> !ev_scl_rise);

    assert_fall_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ev_scl_fall |=> !ev_scl_fall);

    assert_gate_masks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_gate |-> !(ev_start | ev_stop | ev_scl_rise | ev_scl_fall));

    assert_gate_holds_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_gate |=> $stable(rx_bit));

    assert_bit_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_scl_rise |=> $stable(rx_bit));
endmodule

bind i2c_line_cond i2c_lc_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_gate   (bus_gate),
    .ev_start   (ev_start),
    .ev_stop    (ev_stop),
    .ev_scl_rise(ev_scl_rise),
    .ev_scl_fall(ev_scl_fall),
    .rx_bit     (rx_bit)
);

// File: tb/i2c_line_cond_bench.sv
// Self-checking bench: behavioural per-cycle model plus directed scenarios.
module i2c_line_cond_bench;
    localparam int CLK_PERIOD = 10;
    localparam int SPIKE      = 100;
    localparam int FL         = SPIKE / CLK_PERIOD + 1;
    localparam int HALF       = 3 * FL;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda = 1'b1;
    logic gate = 1'b0;
    logic ev_start, ev_stop, ev_scl_rise, ev_scl_fall, rx_bit;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int n_start = 0, n_stop = 0, n_rise = 0, n_fall = 0;

    // behavioural model state: index 0 = SCL, 1 = SDA
    int  m_s1[2], m_s2[2], m_cnt[2], m_filt[2], m_prev[2];
    int  m_rx;
    bit  m_ok = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    i2c_line_cond u_i2c_line_cond (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_raw    (scl),
        .sda_raw    (sda),
        .bus_gate   (gate),
        .ev_start   (ev_start),
        .ev_stop    (ev_stop),
        .ev_scl_rise(ev_scl_rise),
        .ev_scl_fall(ev_scl_fall),
        .rx_bit     (rx_bit)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int m_start();
        return (!gate && m_prev[0] == 1 && m_filt[0] == 1 && m_prev[1] == 1 && m_filt[1] == 0) ? 1 : 0;
    endfunction
    function automatic int m_stop();
        return (!gate && m_prev[0] == 1 && m_filt[0] == 1 && m_prev[1] == 0 && m_filt[1] == 1) ? 1 : 0;
    endfunction
    function automatic int m_rise();
        return (!gate && m_prev[0] == 0 && m_filt[0] == 1) ? 1 : 0;
    endfunction
    function automatic int m_fall();
        return (!gate && m_prev[0] == 1 && m_filt[0] == 0) ? 1 : 0;
    endfunction

    // Model advance on each rising edge (behavioural, old-value ordering).
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 2; i++) begin
                m_s1[i] = 1; m_s2[i] = 1; m_cnt[i] = 0; m_filt[i] = 1; m_prev[i] = 1;
            end
            m_rx = 1;
            m_ok = 1;
        end else if (m_ok) begin
            if (m_rise() == 1) m_rx = m_filt[1];
            for (int i = 0; i < 2; i++) begin
                m_prev[i] = m_filt[i];
                if (m_s2[i] == m_filt[i]) m_cnt[i] = 0;
                else begin
                    m_cnt[i]++;
                    if (m_cnt[i] >= FL) begin
                        m_filt[i] = m_s2[i];
                        m_cnt[i] = 0;
                    end
                end
                m_s2[i] = m_s1[i];
            end
            m_s1[0] = scl;
            m_s1[1] = sda;
        end
    end

    // Per-cycle comparison and event counting, away from the active edge.
    always @(negedge clk) begin
        if (m_ok && !done) begin
            chk(ev_start == m_start(), "R4 model start", ev_start, m_start());
            chk(ev_stop == m_stop(), "R5 model stop", ev_stop, m_stop());
            chk(ev_scl_rise == m_rise(), "R6 model rise", ev_scl_rise, m_rise());
            chk(ev_scl_fall == m_fall(), "R6 model fall", ev_scl_fall, m_fall());
            chk(rx_bit == m_rx, "R7 model rx_bit", rx_bit, m_rx);
            chk($countones({ev_start, ev_stop, ev_scl_rise, ev_scl_fall}) <= 1,
                "R9 exclusive", $countones({ev_start, ev_stop, ev_scl_rise, ev_scl_fall}), 1);
        end
        if (rst_n) begin
            n_start += ev_start; n_stop += ev_stop;
            n_rise += ev_scl_rise; n_fall += ev_scl_fall;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic send_bit(input logic b);
        sda = b; step(HALF);
        scl = 1'b1; step(HALF);
        scl = 1'b0; step(HALF);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        int b_start, b_stop, b_rise, b_fall, lat, rx_keep;
        logic [7:0] byte_v;

        // R1: reset state
        step(4);
        chk({ev_start, ev_stop, ev_scl_rise, ev_scl_fall} == 4'b0, "R1 strobes in reset",
            {ev_start, ev_stop, ev_scl_rise, ev_scl_fall}, 0);
        chk(rx_bit == 1'b1, "R1 rx_bit in reset", rx_bit, 1);
        rst_n = 1'b1;
        step(3 * FL);
        chk(rx_bit == 1'b1 && n_start + n_stop + n_rise + n_fall == 0, "R1 quiet after reset",
            n_start + n_stop + n_rise + n_fall, 0);

        // R2: spikes one sample shorter than the filter, with SCL high
        b_start = n_start; b_stop = n_stop; b_rise = n_rise; b_fall = n_fall;
        sda = 1'b0; step(FL - 1); sda = 1'b1; step(3 * FL);
        scl = 1'b0; step(FL - 1); scl = 1'b1; step(3 * FL);
        sda = 1'b0; step(1); sda = 1'b1; step(3 * FL);
        chk(n_start + n_stop + n_rise + n_fall == b_start + b_stop + b_rise + b_fall,
            "R2 spikes rejected", n_start + n_stop + n_rise + n_fall - b_start - b_stop - b_rise - b_fall, 0);

        // R3 boundary: SCL low pulse of exactly FL cycles is accepted
        b_rise = n_rise; b_fall = n_fall;
        scl = 1'b0; step(FL); scl = 1'b1; step(3 * FL);
        chk(n_fall - b_fall == 1, "R3 exact-length pulse fall", n_fall - b_fall, 1);
        chk(n_rise - b_rise == 1, "R3 exact-length pulse rise", n_rise - b_rise, 1);

        // R3 + R4: start latency
        b_start = n_start;
        sda = 1'b0;
        lat = 0;
        for (int i = 0; i < 4 * FL; i++) begin
            @(negedge clk);
            lat++;
            if (ev_start) break;
        end
        #1;
        chk(lat == FL + 2, "R3 start latency", lat, FL + 2);
        step(2 * FL);
        chk(n_start - b_start == 1, "R4 one start", n_start - b_start, 1);

        // R6 + R7: clock a byte in
        scl = 1'b0; step(HALF);
        byte_v = 8'hA6;
        b_rise = n_rise;
        for (int i = 7; i >= 0; i--) begin
            send_bit(byte_v[i]);
            chk(rx_bit == byte_v[i], "R7 captured bit", rx_bit, byte_v[i]);
        end
        chk(n_rise - b_rise == 8, "R6 rise count", n_rise - b_rise, 8);

        // R10: SDA toggles with SCL low
        b_start = n_start; b_stop = n_stop;
        for (int i = 0; i < 4; i++) begin
            sda = ~sda; step(2 * FL);
        end
        chk(n_start == b_start && n_stop == b_stop, "R10 no start/stop while SCL low",
            n_start + n_stop - b_start - b_stop, 0);

        // R5: stop condition
        sda = 1'b0; step(HALF);
        scl = 1'b1; step(HALF);
        b_stop = n_stop;
        sda = 1'b1; step(HALF);
        chk(n_stop - b_stop == 1, "R5 one stop", n_stop - b_stop, 1);

        // R8: gated transaction
        rx_keep = rx_bit;
        b_start = n_start; b_stop = n_stop; b_rise = n_rise; b_fall = n_fall;
        gate = 1'b1;
        sda = 1'b0; step(HALF);
        scl = 1'b0; step(HALF);
        send_bit(1'b1);
        send_bit(1'b1);
        sda = 1'b0; step(HALF);
        scl = 1'b1; step(HALF);
        sda = 1'b1; step(HALF);
        chk(n_start + n_stop + n_rise + n_fall == b_start + b_stop + b_rise + b_fall,
            "R8 gated events", n_start + n_stop + n_rise + n_fall - b_start - b_stop - b_rise - b_fall, 0);
        chk(rx_bit == rx_keep, "R8 rx_bit frozen", rx_bit, rx_keep);
        gate = 1'b0; step(3 * FL);
        chk(n_start + n_stop + n_rise + n_fall == b_start + b_stop + b_rise + b_fall,
            "R8 no event on release", n_start + n_stop + n_rise + n_fall - b_start - b_stop - b_rise - b_fall, 0);

        // R6: a plain SCL low/high cycle after the gate
        b_rise = n_rise; b_fall = n_fall;
        scl = 1'b0; step(HALF); scl = 1'b1; step(HALF);
        chk(n_fall - b_fall == 1 && n_rise - b_rise == 1, "R6 edges after release",
            n_fall - b_fall + n_rise - b_rise, 2);

        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end
endmodule